// File: doc/BRIEF.md
# Signed Halfword Multiply-Accumulate Unit

This execution unit sits in the integer pipeline of a 32-bit RISC core. It looks at one instruction word per cycle and recognises three signed 16x16 multiply forms: a plain multiply, a multiply that adds a 32-bit accumulator, and a multiply that adds a 64-bit accumulator held in a pair of registers. The register file is outside the block. The unit drives the source register indices out combinationally and takes the operand values back in the same cycle.

For each multiplicand, one instruction bit chooses the upper or lower halfword, and that halfword is sign-extended before the multiply. One cycle after issue, the unit presents up to two register writes with their indices and a `q_set` pulse. The pulse tells the core to set its sticky saturation flag. The flag itself, condition evaluation and the program counter are outside the block.

Top module: `halfmac_unit`

## Requirements
- R1: An instruction is decoded by masking it with 0x0FF00090. A masked value of 0x01000080 selects 32-bit accumulate, 0x01400080 selects 64-bit accumulate and 0x01600080 selects multiply-only. Any other value produces no write enables and no `q_set`. Bits 31:28 do not affect decoding.
- R2: Bit 5 selects the upper halfword of the first multiplicand (`opnd_a`) when set and the lower halfword when clear. Bit 6 does the same for the second multiplicand (`opnd_b`). The chosen halfword is sign-extended and the multiply is signed.
- R3: Multiply-only writes the 32-bit product through the main port to index insn[19:16]. The aux port stays idle and `q_set` stays low.
- R4: 32-bit accumulate writes product plus `acc_lo`, truncated to 32 bits, through the main port to index insn[19:16]. The aux port stays idle.
- R5: In 32-bit accumulate, `q_set` pulses exactly when the signed addition overflows. The wrapped sum is still written.
- R6: 64-bit accumulate adds the sign-extended product to {`acc_hi`,`acc_lo`} modulo 2^64. The low word goes through the aux port to index insn[15:12] and the high word goes through the main port to index insn[19:16]. `q_set` never pulses for this form.
- R7: `res_valid` is `issue_valid` delayed by one cycle. Write enables and `q_set` are only high while `res_valid` is high.
- R8: The read indices are combinational: `rs_a_idx`=insn[3:0], `rs_b_idx`=insn[11:8], `rs_lo_idx`=insn[15:12], `rs_hi_idx`=insn[19:16].
- R9: During synchronous active-low reset, all registered outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | Instruction and operands are valid this cycle |
| insn | input | 32 | Instruction word |
| opnd_a | input | 32 | Value of register rs_a_idx |
| opnd_b | input | 32 | Value of register rs_b_idx |
| acc_lo | input | 32 | Value of register rs_lo_idx |
| acc_hi | input | 32 | Value of register rs_hi_idx |
| rs_a_idx | output | 4 | First multiplicand read index |
| rs_b_idx | output | 4 | Second multiplicand read index |
| rs_lo_idx | output | 4 | Accumulator / low word read index |
| rs_hi_idx | output | 4 | High word read index |
| res_valid | output | 1 | Result stage valid |
| wr_main_en | output | 1 | Main write enable |
| wr_main_idx | output | 4 | Main write index |
| wr_main_data | output | 32 | Main write data |
| wr_aux_en | output | 1 | Aux (low word) write enable |
| wr_aux_idx | output | 4 | Aux write index |
| wr_aux_data | output | 32 | Aux write data |
| q_set | output | 1 | Sets the sticky saturation flag |

## Verification
Some properties are checked on every cycle. The valid strobe must track issue with one cycle of delay. Writes and `q_set` must never appear outside a valid result. The aux write must always come paired with a main write and must target insn[15:12]. Unrecognised encodings must never write. A `q_set` pulse must always carry a result whose sign differs from the accumulator's.

Only the scoreboard scenarios can show that the numbers are right. These cover the halfword choice and sign extension, wrapped sums with both positive and negative overflow, carry and borrow across the 64-bit register pair, and the condition field being ignored.

// File: rtl/halfmac_pkg.sv
// Package: shared op type and decode constants for the halfword MAC unit.
// Assumes a 32-bit instruction word with the encoding fields fixed.
package halfmac_pkg;
    localparam int INSN_W = 32;
    localparam int IDX_W  = 4;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_MUL   = 2'd1,
        OP_ACC32 = 2'd2,
        OP_ACC64 = 2'd3
    } hm_op_e;

    localparam logic [INSN_W-1:0] DEC_MASK  = 32'h0FF0_0090;
    localparam logic [INSN_W-1:0] PAT_ACC32 = 32'h0100_0080;
    localparam logic [INSN_W-1:0] PAT_ACC64 = 32'h0140_0080;
    localparam logic [INSN_W-1:0] PAT_MUL   = 32'h0160_0080;
endpackage

// File: rtl/halfmac_decode.sv
// Decoder: classifies the instruction word into one of the three multiply
// forms and extracts register indices and halfword selects.
// Assumes the condition field (31:28) is evaluated elsewhere.
module halfmac_decode
    import halfmac_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output hm_op_e            op,
    output logic              hi_sel_a,
    output logic              hi_sel_b,
    output logic [IDX_W-1:0]  idx_a,
    output logic [IDX_W-1:0]  idx_b,
    output logic [IDX_W-1:0]  idx_lo,
    output logic [IDX_W-1:0]  idx_hi
);
    logic [INSN_W-1:0] masked;
    logic              cond_unused;

    assign cond_unused = ^insn[31:28];
    assign masked      = insn & DEC_MASK;

    // Pattern match on the masked opcode bits.
    always_comb begin
        unique case (masked)
            PAT_ACC32: op = OP_ACC32;
            PAT_ACC64: op = OP_ACC64;
            PAT_MUL:   op = OP_MUL;
            default:   op = OP_NONE;
        endcase
    end

    assign hi_sel_a = insn[5];
    assign hi_sel_b = insn[6];
    assign idx_a    = insn[3:0];
    assign idx_b    = insn[11:8];
    assign idx_lo   = insn[15:12];
    assign idx_hi   = insn[19:16];
endmodule

// File: rtl/halfmac_halfsel.sv
// Halfword selector: picks the upper or lower half of a word and
// sign-extends it back to the full word width.
// Assumes DATA_W is even.
module halfmac_halfsel #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] word,
    input  logic              take_hi,
    output logic [DATA_W-1:0] ext
);
    localparam int HALF_W = DATA_W / 2;

    logic [HALF_W-1:0] half;

    // Choose the half, then replicate its sign bit upward.
    always_comb begin
        half = take_hi ? word[DATA_W-1:HALF_W] : word[HALF_W-1:0];
        ext  = {{(DATA_W-HALF_W){half[HALF_W-1]}}, half};
    end
endmodule

// File: rtl/halfmac_arith.sv
// Arithmetic core: signed product of two sign-extended halfwords, the
// 32-bit accumulate with overflow detect, and the 64-bit accumulate.
// Assumes both multiplicands are already sign-extended halfwords, so the
// product always fits in DATA_W bits.
module halfmac_arith #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]   mul_a,
    input  logic [DATA_W-1:0]   mul_b,
    input  logic [DATA_W-1:0]   acc_lo,
    input  logic [DATA_W-1:0]   acc_hi,
    output logic [DATA_W-1:0]   prod,
    output logic [DATA_W-1:0]   sum_s,
    output logic                sum_ovf,
    output logic [2*DATA_W-1:0] sum_l
);
    localparam int LONG_W = 2 * DATA_W;

    logic [LONG_W-1:0] prod_l;

    // Signed multiply; the low DATA_W bits hold the exact product.
    always_comb begin
        prod = DATA_W'($signed(mul_a) * $signed(mul_b));
    end

    // Short accumulate and signed overflow of the addition only.
    always_comb begin
        sum_s   = prod + acc_lo;
        sum_ovf = (prod[DATA_W-1] == acc_lo[DATA_W-1]) &&
                  (sum_s[DATA_W-1] != acc_lo[DATA_W-1]);
    end

    // Long accumulate over the register pair, wrapping modulo 2^LONG_W.
    always_comb begin
        prod_l = {{DATA_W{prod[DATA_W-1]}}, prod};
        sum_l  = {acc_hi, acc_lo} + prod_l;
    end
endmodule

// File: rtl/halfmac_unit.sv
// Top: halfword signed multiply-accumulate unit. Decodes the instruction,
// returns read indices to the register file, computes the result and
// registers write-back and the saturation-set pulse with one cycle latency.
// Assumes operand values arrive in the same cycle as the instruction.
module halfmac_unit
    import halfmac_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  logic [31:0]       insn,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [DATA_W-1:0] acc_lo,
    input  logic [DATA_W-1:0] acc_hi,
    output logic [3:0]        rs_a_idx,
    output logic [3:0]        rs_b_idx,
    output logic [3:0]        rs_lo_idx,
    output logic [3:0]        rs_hi_idx,
    output logic              res_valid,
    output logic              wr_main_en,
    output logic [3:0]        wr_main_idx,
    output logic [DATA_W-1:0] wr_main_data,
    output logic              wr_aux_en,
    output logic [3:0]        wr_aux_idx,
    output logic [DATA_W-1:0] wr_aux_data,
    output logic              q_set
);
    localparam int N_OPND = 2;

    hm_op_e            op;
    logic              hi_sel_a, hi_sel_b;
    logic [N_OPND-1:0] hi_sel;
    logic [DATA_W-1:0] raw   [N_OPND];
    logic [DATA_W-1:0] ext   [N_OPND];
    logic [DATA_W-1:0]   prod, sum_s;
    logic                sum_ovf;
    logic [2*DATA_W-1:0] sum_l;

    logic              nx_main_en, nx_aux_en, nx_q;
    logic [DATA_W-1:0] nx_main_data;

    halfmac_decode u_dec (
        .insn     (insn),
        .op       (op),
        .hi_sel_a (hi_sel_a),
        .hi_sel_b (hi_sel_b),
        .idx_a    (rs_a_idx),
        .idx_b    (rs_b_idx),
        .idx_lo   (rs_lo_idx),
        .idx_hi   (rs_hi_idx)
    );

    assign hi_sel = {hi_sel_b, hi_sel_a};
    assign raw[0] = opnd_a;
    assign raw[1] = opnd_b;

    for (genvar g = 0; g < N_OPND; g++) begin : g_sel
        halfmac_halfsel #(.DATA_W(DATA_W)) u_sel (
            .word    (raw[g]),
            .take_hi (hi_sel[g]),
            .ext     (ext[g])
        );
    end

    halfmac_arith #(.DATA_W(DATA_W)) u_arith (
        .mul_a   (ext[0]),
        .mul_b   (ext[1]),
        .acc_lo  (acc_lo),
        .acc_hi  (acc_hi),
        .prod    (prod),
        .sum_s   (sum_s),
        .sum_ovf (sum_ovf),
        .sum_l   (sum_l)
    );

    // Next-state selection of write-back data and enables by op form.
    always_comb begin
        nx_main_en   = issue_valid && (op != OP_NONE);
        nx_aux_en    = issue_valid && (op == OP_ACC64);
        nx_q         = issue_valid && (op == OP_ACC32) && sum_ovf;
        unique case (op)
            OP_ACC32: nx_main_data = sum_s;
            OP_ACC64: nx_main_data = sum_l[2*DATA_W-1:DATA_W];
            default:  nx_main_data = prod;
        endcase
    end

    // Result register stage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid    <= 1'b0;
            wr_main_en   <= 1'b0;
            wr_main_idx  <= '0;
            wr_main_data <= '0;
            wr_aux_en    <= 1'b0;
            wr_aux_idx   <= '0;
            wr_aux_data  <= '0;
            q_set        <= 1'b0;
        end else begin
            res_valid    <= issue_valid;
            wr_main_en   <= nx_main_en;
            wr_main_idx  <= rs_hi_idx;
            wr_main_data <= nx_main_data;
            wr_aux_en    <= nx_aux_en;
            wr_aux_idx   <= rs_lo_idx;
            wr_aux_data  <= sum_l[DATA_W-1:0];
            q_set        <= nx_q;
        end
    end

    // R7
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (res_valid == $past(issue_valid)));
    // R7
    en_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!wr_main_en && !wr_aux_en && !q_set));
    // R5
    q_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_set && $past(rst_n)) |->
            (wr_main_data[DATA_W-1] != $past(acc_lo[DATA_W-1])));
    // R6
    aux_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_aux_en |-> (wr_main_en && !q_set));
    // R6
    aux_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_aux_en && $past(rst_n)) |-> (wr_aux_idx == $past(insn[15:12])));
    // R1
    none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past((insn & DEC_MASK) != PAT_ACC32) &&
         $past((insn & DEC_MASK) != PAT_ACC64) &&
         $past((insn & DEC_MASK) != PAT_MUL)) |-> (!wr_main_en && !q_set));
endmodule

// File: tb/halfmac_unit_tb_top.sv
module halfmac_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic [31:0] insn = '0, opnd_a = '0, opnd_b = '0, acc_lo = '0, acc_hi = '0;
    logic [3:0]  rs_a_idx, rs_b_idx, rs_lo_idx, rs_hi_idx;
    logic        res_valid, wr_main_en, wr_aux_en, q_set;
    logic [3:0]  wr_main_idx, wr_aux_idx;
    logic [31:0] wr_main_data, wr_aux_data;

    int n_chk = 0;
    int n_fail = 0;
    bit summary_done = 0;

    typedef struct {
        bit          m_en;
        logic [3:0]  m_idx;
        logic [31:0] m_data;
        bit          a_en;
        logic [3:0]  a_idx;
        logic [31:0] a_data;
        bit          q;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    halfmac_unit dut_i (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .insn(insn),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .acc_lo(acc_lo), .acc_hi(acc_hi),
        .rs_a_idx(rs_a_idx), .rs_b_idx(rs_b_idx), .rs_lo_idx(rs_lo_idx),
        .rs_hi_idx(rs_hi_idx), .res_valid(res_valid), .wr_main_en(wr_main_en),
        .wr_main_idx(wr_main_idx), .wr_main_data(wr_main_data),
        .wr_aux_en(wr_aux_en), .wr_aux_idx(wr_aux_idx),
        .wr_aux_data(wr_aux_data), .q_set(q_set)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!summary_done) begin
            summary_done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    // Reference model written from the requirements.
    function automatic exp_t model(input logic [31:0] w, input logic [31:0] a,
                                   input logic [31:0] b, input logic [31:0] lo,
                                   input logic [31:0] hi);
        exp_t e;
        logic [31:0] m;
        longint ha, hb, p, s;
        logic [63:0] l;
        m  = w & 32'h0FF00090;
        ha = longint'($signed(w[5] ? a[31:16] : a[15:0]));
        hb = longint'($signed(w[6] ? b[31:16] : b[15:0]));
        p  = ha * hb;
        e  = '{0, w[19:16], 32'h0, 0, w[15:12], 32'h0, 0};
        if (m == 32'h01600080) begin
            e.m_en = 1; e.m_data = p[31:0];
        end else if (m == 32'h01000080) begin
            s = p + longint'($signed(lo));
            e.m_en = 1; e.m_data = s[31:0];
            e.q = (s > 64'sd2147483647) || (s < -64'sd2147483648);
        end else if (m == 32'h01400080) begin
            l = {hi, lo} + p;
            e.m_en = 1; e.m_data = l[63:32];
            e.a_en = 1; e.a_data = l[31:0];
        end
        return e;
    endfunction

    // Driver: applies one instruction and queues its expected result.
    task automatic drive(input logic [31:0] w, input logic [31:0] a,
                         input logic [31:0] b, input logic [31:0] lo,
                         input logic [31:0] hi, input string tag);
        @(negedge clk);
        insn = w; opnd_a = a; opnd_b = b; acc_lo = lo; acc_hi = hi;
        issue_valid = 1'b1;
        exp_q.push_back(model(w, a, b, lo, hi));
        tag_q.push_back(tag);
        #1;
        // R8 read indices straight from the instruction fields
        check({rs_a_idx, rs_b_idx, rs_lo_idx, rs_hi_idx} ==
              {w[3:0], w[11:8], w[15:12], w[19:16]}, "R8", "read idx",
              {48'h0, rs_a_idx, rs_b_idx, rs_lo_idx, rs_hi_idx},
              {48'h0, w[3:0], w[11:8], w[15:12], w[19:16]});
    endtask

    task automatic idle();
        @(negedge clk);
        issue_valid = 1'b0;
        insn = 32'h01400080;
    endtask

    // Monitor: pops and compares on each valid result.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rst_n && res_valid) begin
                if (exp_q.size() == 0) begin
                    check(0, "R7", "unexpected valid", 64'h1, 64'h0);
                end else begin
                    exp_t  e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(wr_main_en == e.m_en && wr_aux_en == e.a_en && q_set == e.q,
                          t, "en/q", {61'h0, wr_main_en, wr_aux_en, q_set},
                          {61'h0, e.m_en, e.a_en, e.q});
                    if (e.m_en)
                        check(wr_main_idx == e.m_idx && wr_main_data == e.m_data, t,
                              "main", {28'h0, wr_main_idx, wr_main_data},
                              {28'h0, e.m_idx, e.m_data});
                    if (e.a_en)
                        check(wr_aux_idx == e.a_idx && wr_aux_data == e.a_data, t,
                              "aux", {28'h0, wr_aux_idx, wr_aux_data},
                              {28'h0, e.a_idx, e.a_data});
                end
            end else if (rst_n) begin
                // R7 no writes without a valid result
                check(!wr_main_en && !wr_aux_en && !q_set, "R7", "idle quiet",
                      {61'h0, wr_main_en, wr_aux_en, q_set}, 64'h0);
            end
        end
    end

    initial begin
        #2000000;
        check(0, "WDOG", "watchdog expired", 64'h1, 64'h0);
        finish_run();
    end

    initial begin
        issue_valid = 1'b1;
        insn = 32'h01600080;
        repeat (3) @(negedge clk);
        // R9 reset clears registered outputs
        check({res_valid, wr_main_en, wr_aux_en, q_set} == 4'h0 &&
              wr_main_data == 0 && wr_aux_data == 0, "R9", "reset state",
              {60'h0, res_valid, wr_main_en, wr_aux_en, q_set}, 64'h0);
        issue_valid = 1'b0;
        rst_n = 1'b1;

        // R3 / R2: multiply-only across all four halfword choices
        drive(32'hE1630281, 32'h8000_7FFF, 32'h0003_FFFE, 0, 0, "R3 lo/lo R2");
        drive(32'hE16302A1, 32'h8000_7FFF, 32'h0003_FFFE, 0, 0, "R3 hi/lo R2");
        drive(32'hE16302C1, 32'h8000_7FFF, 32'h0003_FFFE, 0, 0, "R3 lo/hi R2");
        drive(32'hE16302E1, 32'h8000_7FFF, 32'h0003_FFFE, 0, 0, "R3 hi/hi R2");
        drive(32'h016A0B85, 32'h0000_8000, 32'h0000_8000, 0, 0, "R3 min*min R2");
        // R4 short accumulate, no overflow
        drive(32'hE1074382, 32'h0000_0064, 32'hFFFF_FFFD, 32'h0000_1000, 0, "R4 acc32");
        // R5 positive overflow, wrapped sum written
        drive(32'h01074382, 32'h0000_8000, 32'h0000_8000, 32'h7FFF_FFFF, 0, "R5 pos ovf");
        // R5 negative overflow
        drive(32'h010743C2, 32'h0000_8000, 32'h7FFF_0000, 32'h8000_0000, 0, "R5 neg ovf");
        // R5 boundary without overflow
        drive(32'h01074382, 32'h0000_0001, 32'h0000_0001, 32'h7FFF_FFFE, 0, "R5 edge");
        // R6 long accumulate: carry and borrow across the pair
        drive(32'hE14C5180, 32'h0000_0001, 32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_0000, "R6 carry");
        drive(32'h014C51A0, 32'hFFFF_0000, 32'h0000_0002, 32'h0000_0000, 32'h0000_0005, "R6 borrow");
        drive(32'h014C5180, 32'h0000_8000, 32'h0000_8000, 32'hFFFF_FFFF, 32'h7FFF_FFFF, "R6 wrap no q");
        // R1 non-matching encodings and condition field
        drive(32'h01200080, 32'h0000_0005, 32'h0000_0005, 1, 1, "R1 other op");
        drive(32'h01000090, 32'h0000_0005, 32'h0000_0005, 1, 1, "R1 bit4");
        drive(32'h01000000, 32'h0000_0005, 32'h0000_0005, 1, 1, "R1 bit7");
        drive(32'h51000080, 32'h0000_0003, 32'h0000_0004, 10, 0, "R1 cond ignored");
        idle();
        idle();
        // R7 back-to-back after a gap
        drive(32'h01614382, 32'h0000_0007, 32'h0000_0006, 0, 0, "R7 resume");
        idle();
        idle();
        idle();
        check(exp_q.size() == 0, "R7", "all results seen", 64'(exp_q.size()), 64'h0);
        finish_run();
    end
endmodule